// File: doc/BRIEF.md
# Bloom Filter Membership Unit

This block answers approximate set-membership questions about 16-bit unsigned keys. It holds a 128-bit filter vector that starts empty. Each key is mapped to three bit positions by three fixed shift, XOR and add hashes. Every clock cycle it may take one request, either a lookup or an add. The answer is a single flag that appears on the following cycle. The flag is 1 only when all three positions of the key were already set.

An add reports its answer from the filter as it stood before that add. It then sets its three positions, and the next request sees them. Positions are only ever set. The only way to empty the filter is the synchronous reset. A 1 therefore means "possibly present", and a 0 means "certainly never added".

Top module: `bloom_member_top`

## Requirements
- R1: While `rst` is 1 at a rising edge, the filter is emptied, no request is taken and `maybe_present` is 0 in the next cycle; a request presented during reset leaves no trace.
- R2: A request is taken at a rising edge only when `rst` is 0 and `req_valid` is 1; `req_insert`=1 selects an add, 0 a lookup; with `req_valid`=0 the filter is untouched.
- R3: The three positions are the low 7 bits of: p0 = k ^ (k >> 7); p1 = k + (k >> 4) + 0x2D; p2 = (k << 3) ^ (k >> 2) ^ 0x53, with k the 16-bit key and logical shifts.
- R4: The answer for a taken request, lookup or add, is 1 exactly when filter bits p0, p1 and p2 were all 1 just before that request was taken.
- R5: An add sets bits p0, p1 and p2 and no other bit; a lookup changes no bit.
- R6: The answer for a request taken at edge N is on `maybe_present` between edges N and N+1; requests on consecutive edges give answers on consecutive cycles.
- R7: An add does not see its own bits when forming its answer; a request taken at the very next edge does see them.
- R8: When positions of one key coincide, the key behaves as the set of its distinct positions, with no special handling.
- R9: If no request was taken at the previous edge, `maybe_present` is 0.
- R10: Outside reset, a set filter bit never returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; empties the filter |
| req_valid | input | 1 | Request present this cycle |
| req_insert | input | 1 | 1 = add key, 0 = lookup only |
| key_in | input | 16 | Key of the request |
| maybe_present | output | 1 | Answer for the request taken at the previous edge, else 0 |

## Verification
The hardest state to reach from the ports is a partly filled filter in which the answer for every possible key is known. Only then can the hash positions be confirmed in full, together with the rule that lookups leave the filter alone. The bench builds that state from a set of adds that includes a key with coinciding positions. It then sweeps all 65536 keys as back-to-back lookups against a bench-side copy of the filter. An add followed at once by a lookup of the same key covers the case where an add must not see its own update.

// File: rtl/bloom_pkg.sv
package bloom_pkg;
  localparam int KEY_W    = 16;
  localparam int IDX_W    = 7;
  localparam int NUM_BITS = 1 << IDX_W;
  localparam int NUM_HASH = 3;

  localparam logic [KEY_W-1:0] P1_ADD = KEY_W'(16'h002d);
  localparam logic [KEY_W-1:0] P2_XOR = KEY_W'(16'h0053);

  typedef logic [KEY_W-1:0]                 key_t;
  typedef logic [IDX_W-1:0]                 idx_t;
  typedef logic [NUM_BITS-1:0]              vec_t;
  typedef logic [NUM_HASH-1:0][IDX_W-1:0]   idx_set_t;

  // Position n of key k; the arithmetic is done at full key width and then trimmed.
  function automatic idx_t hash_pos(input int unsigned n, input key_t k);
    key_t t;
    case (n)
      0:       t = k ^ (k >> 7);
      1:       t = k + (k >> 4) + P1_ADD;
      default: t = (k << 3) ^ (k >> 2) ^ P2_XOR;
    endcase
    return t[IDX_W-1:0];
  endfunction

  function automatic vec_t pos_onehot(input idx_t p);
    vec_t v;
    v = '0;
    v[p] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/bloom_hash.sv
module bloom_hash
  import bloom_pkg::*;
(
  input  key_t     key,
  output idx_set_t pos
);
  for (genvar g = 0; g < NUM_HASH; g++) begin : g_pos
    assign pos[g] = hash_pos(g, key);
  end
endmodule

// File: rtl/bloom_decode.sv
module bloom_decode
  import bloom_pkg::*;
(
  input  idx_set_t pos,
  output vec_t     mask
);
  vec_t part [NUM_HASH];

  for (genvar g = 0; g < NUM_HASH; g++) begin : g_dec
    assign part[g] = pos_onehot(pos[g]);
  end

  always_comb begin
    mask = '0;
    for (int i = 0; i < NUM_HASH; i++) begin
      mask = mask | part[i];
    end
  end
endmodule

// File: rtl/bloom_store.sv
module bloom_store
  import bloom_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic set_en,
  input  vec_t set_mask,
  output vec_t bits,
  output logic all_set
);
  vec_t bits_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bits_q <= '0;
    end else if (set_en) begin
      bits_q <= bits_q | set_mask;
    end
  end

  assign bits    = bits_q;
  assign all_set = ((bits_q & set_mask) == set_mask);
endmodule

// File: rtl/bloom_member_top.sv
module bloom_member_top
  import bloom_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_insert,
  input  logic [KEY_W-1:0]  key_in,
  output logic              maybe_present
);
  logic     accept;
  logic     add_now;
  logic     hit_now;
  idx_set_t idx_set;
  vec_t     set_mask;
  vec_t     filter_bits;
  logic     resp_q;

  assign accept  = req_valid & ~rst;
  assign add_now = accept & req_insert;

  bloom_hash u_hash (
    .key (key_in),
    .pos (idx_set)
  );

  bloom_decode u_dec (
    .pos  (idx_set),
    .mask (set_mask)
  );

  bloom_store u_store (
    .clk      (clk),
    .rst      (rst),
    .set_en   (add_now),
    .set_mask (set_mask),
    .bits     (filter_bits),
    .all_set  (hit_now)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_q <= 1'b0;
    end else begin
      resp_q <= accept & hit_now;
    end
  end

  assign maybe_present = resp_q;
endmodule

// File: rtl/bloom_member_chk.sv
module bloom_member_chk
  import bloom_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic req_insert,
  input logic accept,
  input logic hit_now,
  input vec_t set_mask,
  input vec_t filter_bits,
  input logic maybe_present
);
  logic rst_seen;

  always_ff @(posedge clk) rst_seen <= rst;

  always @(negedge clk) begin
    if (rst_seen) begin
      // R1
      reset_clear_chk: assert (!maybe_present && filter_bits == '0);
    end
  end

  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !accept |=> !maybe_present);

  // R6
  resp_next_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> maybe_present == $past(hit_now));

  // R5
  query_keep_chk: assert property (@(posedge clk) disable iff (rst)
    accept && !req_insert |=> filter_bits == $past(filter_bits));

  // R5
  insert_set_chk: assert property (@(posedge clk) disable iff (rst)
    accept && req_insert |=> filter_bits == ($past(filter_bits) | $past(set_mask)));

  // R10
  no_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($past(filter_bits) & ~filter_bits) == '0);

  // R3
  mask_width_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(set_mask) >= 1 && $countones(set_mask) <= NUM_HASH);
endmodule

bind bloom_member_top bloom_member_chk chk_i (
  .clk           (clk),
  .rst           (rst),
  .req_insert    (req_insert),
  .accept        (accept),
  .hit_now       (hit_now),
  .set_mask      (set_mask),
  .filter_bits   (filter_bits),
  .maybe_present (maybe_present)
);

// File: tb/bloom_member_top_tb_top.sv
`timescale 1ns/1ps
module bloom_member_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_insert = 1'b0;
  logic [15:0] key_in = '0;
  logic        maybe_present;

  int checks = 0;
  int fails  = 0;
  logic [127:0] model = '0;
  logic  pend_on  = 1'b0;
  logic  pend_exp = 1'b0;
  string pend_tag = "";

  always #2.5 clk = ~clk;

  bloom_member_top dut_i (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_insert    (req_insert),
    .key_in        (key_in),
    .maybe_present (maybe_present)
  );

  // Positions restated by bit slices of the key.
  function automatic logic [6:0] ref_pos(input int n, input logic [15:0] k);
    logic [6:0] a, b;
    case (n)
      0: ref_pos = k[6:0] ^ k[13:7];
      1: begin a = k[6:0]; b = k[10:4]; ref_pos = a + b + 7'h2d; end
      default: ref_pos = {k[3:0], 3'b000} ^ k[8:2] ^ 7'h53;
    endcase
  endfunction

  function automatic logic [127:0] ref_mask(input logic [15:0] k);
    logic [127:0] m = '0;
    for (int n = 0; n < 3; n++) m[ref_pos(n, k)] = 1'b1;
    return m;
  endfunction

  task automatic check(input string tag, input logic exp);
    checks++;
    if (maybe_present !== exp) begin
      fails++;
      $display("FAIL %s: maybe_present=%b expected=%b", tag, maybe_present, exp);
    end
  endtask

  // One cycle: check the answer of the previous request, then drive this one.
  task automatic step(input logic rs, input logic v, input logic ins,
                      input logic [15:0] k, input string tag);
    logic [127:0] m;
    logic e;
    @(negedge clk);
    if (pend_on) check(pend_tag, pend_exp);
    rst = rs; req_valid = v; req_insert = ins; key_in = k;
    m = ref_mask(k);
    e = 1'b0;
    if (rs) model = '0;
    else if (v) begin
      e = ((model & m) == m);
      if (ins) model = model | m;
    end
    pend_exp = e; pend_tag = tag; pend_on = 1'b1;
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] dup_key;
    dup_key = 16'h0000;
    // R1: reset with a request presented, which must not be taken
    step(1, 1, 1, 16'h1234, "R1");
    step(1, 1, 1, 16'h1234, "R1");
    step(0, 0, 0, 16'h0000, "R1");
    step(0, 1, 0, 16'h1234, "R1");
    // R4: lookups on an empty filter all answer 0
    for (int i = 0; i < 200; i++) step(0, 1, 0, 16'(i * 331), "R4");
    // R7: add then immediate lookup of the same key
    step(0, 1, 1, 16'hbeef, "R7");
    step(0, 1, 0, 16'hbeef, "R7");
    step(0, 1, 1, 16'hbeef, "R4");
    // R9: idle cycle after a hit
    step(0, 1, 0, 16'hbeef, "R9");
    step(0, 0, 1, 16'hbeef, "R9");
    step(0, 0, 0, 16'h0000, "R9");
    // R6: back-to-back adds and lookups
    for (int i = 0; i < 24; i++) step(0, 1, 1, 16'(16'h0101 * i + 7), "R6");
    for (int i = 0; i < 24; i++) step(0, 1, i[0], 16'(16'h0101 * i + 7), "R6");
    // R2: valid low with add select must not change the filter
    for (int i = 0; i < 16; i++) step(0, 0, 1, 16'(16'h4000 + i * 97), "R2");
    for (int i = 0; i < 16; i++) step(0, 1, 0, 16'(16'h4000 + i * 97), "R2");
    // R10: an early key is still reported after many adds
    step(0, 1, 0, 16'hbeef, "R10");
    // R1: mid-run reset empties the filter
    step(1, 0, 0, 16'h0000, "R1");
    step(0, 1, 0, 16'hbeef, "R1");
    // R8: key whose positions coincide
    for (int k = 0; k < 65536; k++) begin
      if (ref_pos(0, 16'(k)) == ref_pos(1, 16'(k)) ||
          ref_pos(1, 16'(k)) == ref_pos(2, 16'(k)) ||
          ref_pos(0, 16'(k)) == ref_pos(2, 16'(k))) begin
        dup_key = 16'(k);
        break;
      end
    end
    step(0, 1, 1, dup_key, "R8");
    step(0, 1, 0, dup_key, "R8");
    for (int i = 0; i < 40; i++) step(0, 1, 1, 16'(i * 1637 + 11), "R5");
    // R3: full sweep of every key against the bench filter copy
    for (int k = 0; k < 65536; k++) step(0, 1, 0, 16'(k), "R3");
    step(0, 0, 0, 16'h0000, "R9");
    step(0, 0, 0, 16'h0000, "R9");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule